// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator for a Power-Management Device

This block gathers single-cycle event pulses from the power-management sources of a chip and turns them into one active-low interrupt line for a host processor. Events from the battery/thermal, buck converter, linear regulator and on/off sources are captured in per-group status registers. A per-group mask decides whether a captured bit counts toward its group. The real-time clock, oscillator and version-error sources have no group register. They are sampled straight into the top level. A top-level status byte summarises all eight sources, and a top-level mask gates each of them onto the interrupt line.

The host reaches every register through a simple byte-addressed port. Reading a group status register returns its captured bits and clears them in the same access, which is how the host acknowledges events and flushes stale ones. Every mask bit comes out of reset set, so the line stays quiet until software opens a path. The line is driven by a two-state machine. `LINE_IDLE` holds the line high. The transition `go_assert` moves it to `LINE_ASSERT`, which holds the line low, when an unmasked top-level bit is present at a clock edge. The transition `go_release` returns it to `LINE_IDLE` when no such bit remains. Each state otherwise holds.

Top module: `pmu_irq_hub`

## Requirements
- R1: After reset every mask register reads all ones on its implemented bits: 0x0D, 0x10, 0x11 and 0x12 read 0xFF, 0x0E reads 0x0F and 0x0F reads 0xF8. Every status register reads 0x00 and `irq_n` is high.
- R2: An event pulse sets its bit in the group status register, and the bit stays set until that register is read. Placement: battery/thermal at 0x06 puts low battery, thermal alarm 1 and thermal alarm 2 on bits 3, 2 and 1. Buck events 0..4 sit on bits 3..7 of 0x07. Regulator events 0..7 are in 0x08 and 8..15 in 0x09. GPIO events 0..7 are in 0x0A. On/off events 0..7 are in 0x0B (hard power-down, enable held 1 s, enable falling, enable rising, lid falling, lid rising, AC-ok falling, AC-ok rising). A read strobe returns its data on `reg_rdata` from the next clock edge on.
- R3: A read of a group status register returns the captured value and clears exactly that register; a second read returns 0x00 and other registers keep their bits.
- R4: An event arriving in the same cycle as a clearing read of its register is not returned by that read but remains captured for the next one.
- R5: The top-level status at 0x05 has bit 7 battery/thermal, 6 buck, 5 regulator, 4 GPIO, 3 real-time clock, 2 oscillator, 1 on/off, 0 version error. A group bit is 1 while its group holds a captured bit whose group mask bit is 0. The GPIO bit is 1 while any GPIO status bit is set.
- R6: Bits 3, 2 and 0 of the top-level status equal the real-time clock, oscillator and version-error inputs one clock after they are sampled, and are not latched.
- R7: Bit 0 of the battery/thermal mask at 0x0E masks the whole group, so top-level bit 7 stays 0 while it is set, whatever bits 3..1 hold.
- R8: The regulator mask is 16 bits wide; 0x10 masks events 0..7 and 0x11 masks events 8..15.
- R9: `irq_n` goes low one clock edge after a top-level status bit is 1 with its bit in the top-level mask at 0x0D (same layout as 0x05) equal to 0, and returns high one edge after no such bit remains.
- R10: Writes to status registers, including 0x05, have no effect. Unmapped addresses read 0x00. Mask registers read back the written value with unimplemented bits as 0 (0x0E bits 7..4, 0x0F bits 2..0).
- R11: Reading the top-level status at 0x05 clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_batt | input | 3 | Battery/thermal event pulses: [2] low battery, [1] thermal alarm 1, [0] thermal alarm 2 |
| evt_buck | input | 5 | Buck converter event pulses |
| evt_ldo | input | 16 | Linear regulator event pulses |
| evt_gpio | input | 8 | GPIO event pulses |
| evt_onoff | input | 8 | On/off controller event pulses |
| evt_rtc | input | 1 | Real-time clock interrupt level |
| evt_osc | input | 1 | Oscillator interrupt level |
| evt_verr | input | 1 | Version-error interrupt level |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, held until the next read |
| irq_n | output | 1 | Active-low interrupt to the host |

## Verification
The assertions assume that read and write strobes are never active in the same cycle. They also assume the three direct-level inputs are low while reset is held, and the bench only ever raises one strobe at a time and drives every event input to zero through reset. Event pulses are applied for a single cycle on the falling clock edge, one source bit at a time in the sweeps. The one deliberate overlap is an on/off event placed in the same cycle as a clearing read of its register. The assertions on the interrupt line take the top-level status and mask as given and check only the one-edge response of the line machine.

// File: rtl/pmu_irq_pkg.sv
package pmu_irq_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 8;

    localparam int BATT_EVT_W  = 3;
    localparam int BUCK_EVT_W  = 5;
    localparam int LDO_EVT_W   = 16;
    localparam int GPIO_EVT_W  = 8;
    localparam int ONOFF_EVT_W = 8;

    localparam int BATT_LSB     = 1;
    localparam int BATT_MASK_W  = BATT_EVT_W + 1;
    localparam int BUCK_LSB     = REG_DW - BUCK_EVT_W;
    localparam int LDO_BYTES    = LDO_EVT_W / REG_DW;

    localparam logic [REG_AW-1:0] A_TOP_STAT    = 8'h05;
    localparam logic [REG_AW-1:0] A_BATT_STAT   = 8'h06;
    localparam logic [REG_AW-1:0] A_BUCK_STAT   = 8'h07;
    localparam logic [REG_AW-1:0] A_LDO_STAT0   = 8'h08;
    localparam logic [REG_AW-1:0] A_GPIO_STAT   = 8'h0A;
    localparam logic [REG_AW-1:0] A_ONOFF_STAT  = 8'h0B;
    localparam logic [REG_AW-1:0] A_TOP_MASK    = 8'h0D;
    localparam logic [REG_AW-1:0] A_BATT_MASK   = 8'h0E;
    localparam logic [REG_AW-1:0] A_BUCK_MASK   = 8'h0F;
    localparam logic [REG_AW-1:0] A_LDO_MASK0   = 8'h10;
    localparam logic [REG_AW-1:0] A_ONOFF_MASK  = 8'h12;

    localparam int TB_BATT  = 7;
    localparam int TB_BUCK  = 6;
    localparam int TB_LDO   = 5;
    localparam int TB_GPIO  = 4;
    localparam int TB_RTC   = 3;
    localparam int TB_OSC   = 2;
    localparam int TB_ONOFF = 1;
    localparam int TB_VERR  = 0;

    typedef enum logic [0:0] {
        LINE_IDLE   = 1'b0,
        LINE_ASSERT = 1'b1
    } line_state_e;

endpackage

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr,
    output logic [W-1:0] q
);
    // Clear and set in one step: a new event always wins over the clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q & ~{W{clr}}) | evt;
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else if (we) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import pmu_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_n
);
    line_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:   if (pending)  state_d = LINE_ASSERT; // go_assert
            LINE_ASSERT: if (!pending) state_d = LINE_IDLE;   // go_release
            default:     state_d = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            LINE_ASSERT: irq_n = 1'b0;
            default:     irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/pmu_irq_hub.sv
module pmu_irq_hub
    import pmu_irq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BATT_EVT_W-1:0]  evt_batt,
    input  logic [BUCK_EVT_W-1:0]  evt_buck,
    input  logic [LDO_EVT_W-1:0]   evt_ldo,
    input  logic [GPIO_EVT_W-1:0]  evt_gpio,
    input  logic [ONOFF_EVT_W-1:0] evt_onoff,
    input  logic                   evt_rtc,
    input  logic                   evt_osc,
    input  logic                   evt_verr,
    input  logic                   reg_rd,
    input  logic                   reg_wr,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [REG_DW-1:0]      reg_wdata,
    output logic [REG_DW-1:0]      reg_rdata,
    output logic                   irq_n
);
    // ---------------- group status and masks ----------------
    logic [BATT_EVT_W-1:0]  batt_stat;
    logic [BATT_MASK_W-1:0] batt_mask;
    logic [BUCK_EVT_W-1:0]  buck_stat;
    logic [BUCK_EVT_W-1:0]  buck_mask;
    logic [LDO_EVT_W-1:0]   ldo_stat;
    logic [LDO_EVT_W-1:0]   ldo_mask;
    logic [GPIO_EVT_W-1:0]  gpio_stat;
    logic [ONOFF_EVT_W-1:0] onoff_stat;
    logic [ONOFF_EVT_W-1:0] onoff_mask;
    logic [REG_DW-1:0]      top_mask;
    logic [REG_DW-1:0]      top_stat;
    logic                   rtc_q, osc_q, verr_q;

    logic rd_batt, rd_buck, rd_gpio, rd_onoff;
    assign rd_batt  = reg_rd && (reg_addr == A_BATT_STAT);
    assign rd_buck  = reg_rd && (reg_addr == A_BUCK_STAT);
    assign rd_gpio  = reg_rd && (reg_addr == A_GPIO_STAT);
    assign rd_onoff = reg_rd && (reg_addr == A_ONOFF_STAT);

    irq_status_latch #(.W(BATT_EVT_W)) u_batt_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt_batt), .clr(rd_batt), .q(batt_stat));
    irq_mask_reg #(.W(BATT_MASK_W)) u_batt_mask (
        .clk(clk), .rst_n(rst_n),
        .we(reg_wr && (reg_addr == A_BATT_MASK)),
        .wdata(reg_wdata[BATT_MASK_W-1:0]), .q(batt_mask));

    irq_status_latch #(.W(BUCK_EVT_W)) u_buck_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt_buck), .clr(rd_buck), .q(buck_stat));
    irq_mask_reg #(.W(BUCK_EVT_W)) u_buck_mask (
        .clk(clk), .rst_n(rst_n),
        .we(reg_wr && (reg_addr == A_BUCK_MASK)),
        .wdata(reg_wdata[REG_DW-1:BUCK_LSB]), .q(buck_mask));

    // Regulator group: one status byte and one mask byte per address step.
    for (genvar b = 0; b < LDO_BYTES; b++) begin : g_ldo
        localparam logic [REG_AW-1:0] STAT_A = A_LDO_STAT0 + REG_AW'(b);
        localparam logic [REG_AW-1:0] MASK_A = A_LDO_MASK0 + REG_AW'(b);
        irq_status_latch #(.W(REG_DW)) u_stat (
            .clk(clk), .rst_n(rst_n),
            .evt(evt_ldo[b*REG_DW +: REG_DW]),
            .clr(reg_rd && (reg_addr == STAT_A)),
            .q(ldo_stat[b*REG_DW +: REG_DW]));
        irq_mask_reg #(.W(REG_DW)) u_mask (
            .clk(clk), .rst_n(rst_n),
            .we(reg_wr && (reg_addr == MASK_A)),
            .wdata(reg_wdata),
            .q(ldo_mask[b*REG_DW +: REG_DW]));
    end

    irq_status_latch #(.W(GPIO_EVT_W)) u_gpio_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt_gpio), .clr(rd_gpio), .q(gpio_stat));

    irq_status_latch #(.W(ONOFF_EVT_W)) u_onoff_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt_onoff), .clr(rd_onoff), .q(onoff_stat));
    irq_mask_reg #(.W(ONOFF_EVT_W)) u_onoff_mask (
        .clk(clk), .rst_n(rst_n),
        .we(reg_wr && (reg_addr == A_ONOFF_MASK)),
        .wdata(reg_wdata), .q(onoff_mask));

    irq_mask_reg #(.W(REG_DW)) u_top_mask (
        .clk(clk), .rst_n(rst_n),
        .we(reg_wr && (reg_addr == A_TOP_MASK)),
        .wdata(reg_wdata), .q(top_mask));

    // Sources without a group register: sampled, not held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rtc_q  <= 1'b0;
            osc_q  <= 1'b0;
            verr_q <= 1'b0;
        end else begin
            rtc_q  <= evt_rtc;
            osc_q  <= evt_osc;
            verr_q <= evt_verr;
        end
    end

    // ---------------- top-level summary ----------------
    always_comb begin
        top_stat           = '0;
        top_stat[TB_BATT]  = !batt_mask[0] && |(batt_stat & ~batt_mask[BATT_MASK_W-1:BATT_LSB]);
        top_stat[TB_BUCK]  = |(buck_stat & ~buck_mask);
        top_stat[TB_LDO]   = |(ldo_stat & ~ldo_mask);
        top_stat[TB_GPIO]  = |gpio_stat;
        top_stat[TB_RTC]   = rtc_q;
        top_stat[TB_OSC]   = osc_q;
        top_stat[TB_ONOFF] = |(onoff_stat & ~onoff_mask);
        top_stat[TB_VERR]  = verr_q;
    end

    irq_line_fsm u_line (
        .clk(clk), .rst_n(rst_n),
        .pending(|(top_stat & ~top_mask)),
        .irq_n(irq_n));

    // ---------------- read port ----------------
    logic [REG_DW-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            A_TOP_STAT:   rd_mux = top_stat;
            A_BATT_STAT:  rd_mux[BATT_MASK_W-1:BATT_LSB] = batt_stat;
            A_BUCK_STAT:  rd_mux[REG_DW-1:BUCK_LSB] = buck_stat;
            A_GPIO_STAT:  rd_mux = gpio_stat;
            A_ONOFF_STAT: rd_mux = onoff_stat;
            A_TOP_MASK:   rd_mux = top_mask;
            A_BATT_MASK:  rd_mux[BATT_MASK_W-1:0] = batt_mask;
            A_BUCK_MASK:  rd_mux[REG_DW-1:BUCK_LSB] = buck_mask;
            A_ONOFF_MASK: rd_mux = onoff_mask;
            default: begin
                for (int b = 0; b < LDO_BYTES; b++) begin
                    if (reg_addr == A_LDO_STAT0 + REG_AW'(b))
                        rd_mux = ldo_stat[b*REG_DW +: REG_DW];
                    if (reg_addr == A_LDO_MASK0 + REG_AW'(b))
                        rd_mux = ldo_mask[b*REG_DW +: REG_DW];
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/pmu_irq_hub_chk.sv
module pmu_irq_hub_chk
    import pmu_irq_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_rd,
    input logic                   reg_wr,
    input logic [REG_AW-1:0]      reg_addr,
    input logic [REG_DW-1:0]      reg_wdata,
    input logic [ONOFF_EVT_W-1:0] evt_onoff,
    input logic                   evt_rtc,
    input logic [ONOFF_EVT_W-1:0] onoff_stat,
    input logic [REG_DW-1:0]      top_stat,
    input logic [REG_DW-1:0]      top_mask,
    input logic                   irq_n
);
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == A_ONOFF_STAT)
        |=> ((onoff_stat & $past(onoff_stat)) == $past(onoff_stat)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_ONOFF_STAT) |=> (onoff_stat == $past(evt_onoff)));

    p_keep_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_ONOFF_STAT && |evt_onoff) |=> |onoff_stat);

    p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (top_stat[TB_RTC] == $past(evt_rtc)));

    p_group_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_BATT_MASK && reg_wdata[0]) |=> !top_stat[TB_BATT]);

    p_line_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        |(top_stat & ~top_mask) |=> !irq_n);

    p_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(top_stat & ~top_mask)) |=> irq_n);
endmodule

bind pmu_irq_hub pmu_irq_hub_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .evt_onoff(evt_onoff),
    .evt_rtc(evt_rtc), .onoff_stat(onoff_stat), .top_stat(top_stat),
    .top_mask(top_mask), .irq_n(irq_n));

// File: tb/pmu_irq_hub_tb.sv
module pmu_irq_hub_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt_batt = '0;
    logic [4:0]  evt_buck = '0;
    logic [15:0] evt_ldo = '0;
    logic [7:0]  evt_gpio = '0;
    logic [7:0]  evt_onoff = '0;
    logic        evt_rtc = 1'b0, evt_osc = 1'b0, evt_verr = 1'b0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0, reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pmu_irq_hub u_dut (
        .clk(clk), .rst_n(rst_n), .evt_batt(evt_batt), .evt_buck(evt_buck),
        .evt_ldo(evt_ldo), .evt_gpio(evt_gpio), .evt_onoff(evt_onoff),
        .evt_rtc(evt_rtc), .evt_osc(evt_osc), .evt_verr(evt_verr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n));

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        logic [7:0] d;
        rd(a, d);
        check(d, exp, req);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // grp: 0 batt, 1 buck, 2 ldo, 3 gpio, 4 onoff
    task automatic pulse(input int grp, input logic [15:0] v);
        @(negedge clk);
        case (grp)
            0: evt_batt = v[2:0];
            1: evt_buck = v[4:0];
            2: evt_ldo = v;
            3: evt_gpio = v[7:0];
            default: evt_onoff = v[7:0];
        endcase
        @(negedge clk);
        evt_batt = '0; evt_buck = '0; evt_ldo = '0; evt_gpio = '0; evt_onoff = '0;
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check({7'd0, irq_n}, 8'h01, "R1 irq_n");
        rd_chk(8'h0D, 8'hFF, "R1 top mask");
        rd_chk(8'h0E, 8'h0F, "R1 batt mask");
        rd_chk(8'h0F, 8'hF8, "R1 buck mask");
        rd_chk(8'h10, 8'hFF, "R1 ldo mask lo");
        rd_chk(8'h11, 8'hFF, "R1 ldo mask hi");
        rd_chk(8'h12, 8'hFF, "R1 onoff mask");
        for (int a = 5; a <= 11; a++) rd_chk(8'(a), 8'h00, "R1 status");

        // R10 unmapped addresses
        rd_chk(8'h00, 8'h00, "R10 unmapped");
        rd_chk(8'h13, 8'h00, "R10 unmapped");
        rd_chk(8'hFF, 8'h00, "R10 unmapped");

        // On/off sweep: R2 R3 R5 R11
        for (int k = 0; k < 8; k++) begin
            pulse(4, 16'(1 << k));
            rd_chk(8'h05, 8'h00, "R5 masked group");
            wr(8'h12, 8'(~(1 << ((k + 1) % 8))));
            rd_chk(8'h05, 8'h00, "R5 other bit unmasked");
            wr(8'h12, 8'(~(1 << k)));
            rd_chk(8'h05, 8'h02, "R5 onoff top bit");
            rd_chk(8'h05, 8'h02, "R11 top read keeps");
            rd_chk(8'h0B, 8'(1 << k), "R2 onoff capture");
            rd_chk(8'h0B, 8'h00, "R3 onoff cleared");
            rd_chk(8'h05, 8'h00, "R5 top after clear");
            wr(8'h12, 8'hFF);
        end

        // Battery/thermal sweep: R2 R7
        for (int i = 0; i < 3; i++) begin
            pulse(0, 16'(1 << i));
            wr(8'h0E, 8'(~(1 << (i + 1))) | 8'h01);
            rd_chk(8'h05, 8'h00, "R7 group mask bit set");
            wr(8'h0E, 8'(~(1 << (i + 1))) & 8'hFE);
            rd_chk(8'h05, 8'h80, "R7 group mask bit clear");
            rd_chk(8'h06, 8'(1 << (i + 1)), "R2 batt capture");
            rd_chk(8'h06, 8'h00, "R3 batt cleared");
            wr(8'h0E, 8'hFF);
        end
        rd_chk(8'h0E, 8'h0F, "R10 batt mask width");

        // Buck sweep: R2 R5 R10
        for (int j = 0; j < 5; j++) begin
            pulse(1, 16'(1 << j));
            wr(8'h0F, 8'(~(1 << (j + 3))));
            rd_chk(8'h05, 8'h40, "R5 buck top bit");
            rd_chk(8'h07, 8'(1 << (j + 3)), "R2 buck capture");
            rd_chk(8'h07, 8'h00, "R3 buck cleared");
        end
        wr(8'h0F, 8'h00);
        rd_chk(8'h0F, 8'h00, "R10 buck mask zero");
        wr(8'h0F, 8'hFF);
        rd_chk(8'h0F, 8'hF8, "R10 buck mask width");

        // Regulator sweep: R8 R3
        for (int b = 0; b < 16; b++) begin
            pulse(2, 16'(1 << b));
            wr(8'h10 + 8'(1 - b / 8), 8'(~(1 << (b % 8))));
            rd_chk(8'h05, 8'h00, "R8 other byte mask");
            wr(8'h10 + 8'(1 - b / 8), 8'hFF);
            wr(8'h10 + 8'(b / 8), 8'(~(1 << (b % 8))));
            rd_chk(8'h05, 8'h20, "R8 ldo top bit");
            rd_chk(8'h08 + 8'(1 - b / 8), 8'h00, "R3 other byte");
            rd_chk(8'h08 + 8'(b / 8), 8'(1 << (b % 8)), "R2 ldo capture");
            rd_chk(8'h08 + 8'(b / 8), 8'h00, "R3 ldo cleared");
            wr(8'h10 + 8'(b / 8), 8'hFF);
        end

        // GPIO sweep: R5
        for (int g = 0; g < 8; g++) begin
            pulse(3, 16'(1 << g));
            rd_chk(8'h05, 8'h10, "R5 gpio top bit");
            rd_chk(8'h0A, 8'(1 << g), "R2 gpio capture");
            rd_chk(8'h0A, 8'h00, "R3 gpio cleared");
        end

        // Direct sources: R6
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            evt_rtc = (s == 0); evt_osc = (s == 1); evt_verr = (s == 2);
            rd_chk(8'h05, (s == 0) ? 8'h08 : (s == 1) ? 8'h04 : 8'h01, "R6 direct level");
            evt_rtc = 1'b0; evt_osc = 1'b0; evt_verr = 1'b0;
            rd_chk(8'h05, 8'h00, "R6 not latched");
        end

        // R10 writes to status registers ignored
        pulse(4, 16'h0010);
        wr(8'h0B, 8'h00);
        wr(8'h05, 8'hFF);
        wr(8'h06, 8'h0E);
        rd_chk(8'h06, 8'h00, "R10 batt status write");
        rd_chk(8'h0B, 8'h10, "R10 onoff status write");

        // R4 event concurrent with clearing read
        pulse(4, 16'h0001);
        @(negedge clk); reg_rd = 1'b1; reg_addr = 8'h0B; evt_onoff = 8'h80;
        @(negedge clk); reg_rd = 1'b0; evt_onoff = 8'h00;
        check(reg_rdata, 8'h01, "R4 read returns old");
        rd_chk(8'h0B, 8'h80, "R4 new event kept");

        // R9 interrupt line
        @(negedge clk); evt_rtc = 1'b1;
        repeat (2) @(negedge clk);
        check({7'd0, irq_n}, 8'h01, "R9 top masked");
        wr(8'h0D, 8'hFB);
        @(negedge clk);
        check({7'd0, irq_n}, 8'h01, "R9 other top bit open");
        wr(8'h0D, 8'hF7);
        check({7'd0, irq_n}, 8'h01, "R9 not yet");
        @(negedge clk);
        check({7'd0, irq_n}, 8'h00, "R9 asserted");
        evt_rtc = 1'b0;
        @(negedge clk);
        check({7'd0, irq_n}, 8'h00, "R9 still low");
        @(negedge clk);
        check({7'd0, irq_n}, 8'h01, "R9 released");
        wr(8'h0D, 8'hFD);
        wr(8'h12, 8'hF7);
        @(negedge clk); evt_onoff = 8'h08;
        @(negedge clk); evt_onoff = 8'h00;
        check({7'd0, irq_n}, 8'h01, "R9 one edge latency");
        @(negedge clk);
        check({7'd0, irq_n}, 8'h00, "R9 onoff asserted");
        rd(8'h0B, d);
        check(d, 8'h08, "R9 onoff status");
        check({7'd0, irq_n}, 8'h00, "R9 low right after clear");
        @(negedge clk);
        check({7'd0, irq_n}, 8'h01, "R9 released after clear");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule